// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wakeup

This block recovers characters from an asynchronous serial line. Every bit is sampled at its midpoint, using a 16x oversampling tick from an external divider. A character is a low start bit, then eight or nine data bits sent least significant bit first, then one stop bit. When parity is on, the final data bit holds the parity. Each completed character is reported with a one-cycle valid strobe, together with parity-error and framing-error flags.

A line-idle detector raises a one-cycle idle flag after a full character time of continuous marking. One mode counts from the end of the start bit, so the trailing ones of a character help reach idle. The other mode counts only once the stop bit has been sampled. A host that does not care about the current traffic can put the receiver into standby. While in standby, characters are not reported. Standby ends by itself on one of two events, chosen by a select input: a detected idle line, or an address-marked character, which is a character whose last data bit is set. A loopback selector picks the serial input from three sources: the receive pin, the internal transmitter output or the transmit pin.

Top module: `sci_rx_wake`

## Requirements
- R1: With `fmt9`=0 a character is a start bit, 8 data bits sent LSB first and one stop bit. `rx_data[7:0]` holds the data, `rx_data[8]` is 0 and `rx_valid` pulses for one cycle.
- R2: With `fmt9`=1 a ninth data bit follows bit 7 and appears in `rx_data[8]`.
- R3: With `par_en`=1 the last data bit (`rx_data[7]` in 8-bit format, `rx_data[8]` in 9-bit format) is parity. `par_err` is set when the count of ones over all data bits, parity included, is odd with `par_odd`=0 or even with `par_odd`=1. With `par_en`=0, `par_err` is 0.
- R4: A stop bit sampled low sets `frm_err` alongside the delivered character.
- R5: A falling edge that is high again at the mid-start sample is rejected and produces no character.
- R6: With `idle_long`=0, consecutive ones are counted from the end of the start bit. `idle_flag` pulses after 10 bit times of marking (11 bit times in 9-bit format), so the trailing data ones and the stop bit shorten the wait.
- R7: With `idle_long`=1, counting starts only after the stop bit has been sampled.
- R8: `idle_flag` pulses at most once per idle period. It is armed only by a completed character, so it never fires after reset until a character has been received.
- R9: `sleep_req` puts the receiver into standby (`asleep`=1). While in standby, characters that do not wake it produce no `rx_valid`.
- R10: With `wake_addr`=0, an idle-line detection clears `asleep`, and later characters are delivered.
- R11: With `wake_addr`=1, a character whose last data bit is set clears `asleep` and is itself delivered. Other characters and idle detection leave `asleep` at 1.
- R12: With `lpbk_en`=0 the input is `rx_pin`. With `lpbk_en`=1 the input is `tx_int` when `lpbk_src`=0 and `tx_pin` when `lpbk_src`=1.
- R13: After reset, `rx_valid`, `rx_data`, `par_err`, `frm_err`, `idle_flag` and `asleep` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x oversampling enable from the baud divider |
| rx_pin | input | 1 | Serial receive pin |
| tx_int | input | 1 | Internal transmitter output, used for loopback |
| tx_pin | input | 1 | Transmit pin level, used for loopback |
| lpbk_en | input | 1 | Loopback enable |
| lpbk_src | input | 1 | Loopback source: 0 internal transmitter, 1 transmit pin |
| fmt9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| idle_long | input | 1 | Idle counting: 0 from the end of the start bit, 1 after the stop bit |
| wake_addr | input | 1 | Wake event: 0 idle line, 1 address-marked character |
| sleep_req | input | 1 | Pulse that enters standby |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | One-cycle strobe for a delivered character |
| par_err | output | 1 | Parity error of the delivered character |
| frm_err | output | 1 | Framing error of the delivered character |
| idle_flag | output | 1 | One-cycle idle-line pulse |
| asleep | output | 1 | Standby state |

## Verification
Two events can fall in the same clock cycle. In address-mark wakeup, the stop-bit sample of a marked character both clears standby and delivers that same character. The bench provokes this by entering standby with `wake_addr`=1, sending an unmarked character, and then sending a marked one, in both formats. It judges the result by the strobe count, the delivered value and `asleep`. A second overlap is a completed character arming the idle detector while the idle counter is already running in short mode. The bench exposes this by timing the idle pulse after an all-ones character in each idle mode.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;
  localparam int unsigned OVS_DEF   = 16;
  localparam int unsigned CHAR_W    = 9;
  localparam int unsigned SYNC_DEF  = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_st_e;
endpackage

// File: rtl/sci_rx_src.sv
// Input source selection followed by a metastability synchronizer.
module sci_rx_src #(
  parameter int unsigned STAGES = sci_rx_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lpbk_en,
  input  logic lpbk_src,
  input  logic rx_pin,
  input  logic tx_int,
  input  logic tx_pin,
  output logic line
);
  logic              raw;
  logic [STAGES-1:0] sync_q;

  // R12: source selection
  always_comb begin
    if (!lpbk_en)      raw = rx_pin;
    else if (lpbk_src) raw = tx_pin;
    else               raw = tx_int;
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign line = sync_q[STAGES-1];
endmodule

// File: rtl/sci_rx_frame.sv
// Mid-bit sampling frame engine.
module sci_rx_frame
  import sci_rx_pkg::*;
#(
  parameter int unsigned OVS = OVS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  input  logic              fmt9,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [CHAR_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              addr_mark,
  output logic              busy
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned BW   = $clog2(CHAR_W);
  localparam logic [CW-1:0] HALF = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OVS - 1);

  rx_st_e            st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic [BW-1:0]     last_bit;

  assign last_bit = fmt9 ? BW'(CHAR_W - 1) : BW'(CHAR_W - 2);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    if (tick) begin
      case (st_q)
        ST_IDLE: begin
          if (!line) begin
            st_d  = ST_START;
            cnt_d = '0;
          end
        end
        ST_START: begin
          if (cnt_q == HALF) begin
            cnt_d = '0;
            if (!line) begin
              st_d  = ST_DATA;
              bit_d = '0;
              sh_d  = '0;
            end else begin
              st_d  = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt_q == FULL) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[CHAR_W-1:1]};
            if (bit_q == last_bit) st_d  = ST_STOP;
            else                   bit_d = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == FULL) begin
            cnt_d = '0;
            st_d  = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign done      = (st_q == ST_STOP) && tick && (cnt_q == FULL);
  assign data      = fmt9 ? sh_q : {1'b0, sh_q[CHAR_W-1:1]};
  assign perr      = par_en & ((^data) ^ par_odd);
  assign ferr      = ~line;
  assign addr_mark = fmt9 ? data[CHAR_W-1] : data[CHAR_W-2];
  assign busy      = (st_q != ST_IDLE);

  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && tick && cnt_q == HALF && line) |=> (st_q == ST_IDLE)); // R5
endmodule

// File: rtl/sci_rx_idle.sv
// Idle-line detector with short/long counting start and single-shot arming.
module sci_rx_idle #(
  parameter int unsigned OVS = sci_rx_pkg::OVS_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic fmt9,
  input  logic long_mode,
  input  logic busy,
  input  logic frame_done,
  output logic idle_pulse
);
  localparam int unsigned THR8 = 10 * OVS;
  localparam int unsigned THR9 = 11 * OVS;
  localparam int unsigned ICW  = $clog2(THR9 + 1);

  logic [ICW-1:0] cnt_q, cnt_d, thr;
  logic           armed_q, armed_d, idle_q, idle_d;
  logic           run, hit;

  assign thr = fmt9 ? ICW'(THR9) : ICW'(THR8);
  assign run = line && !(long_mode && busy);
  assign hit = run && tick && (cnt_q == thr - 1'b1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                      cnt_d = '0;
    else if (tick && cnt_q != thr) cnt_d = cnt_q + 1'b1;
    armed_d = frame_done | (armed_q & ~hit);
    idle_d  = hit & armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      idle_q  <= idle_d;
    end
  end

  assign idle_pulse = idle_q;

  AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |=> !idle_q); // R8
  AST_LONG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (long_mode && busy) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/sci_rx_wake.sv
// Top: serial receiver with standby and wakeup.
module sci_rx_wake
  import sci_rx_pkg::*;
#(
  parameter int unsigned OVS   = OVS_DEF,
  parameter int unsigned SYNCN = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rx_pin,
  input  logic              tx_int,
  input  logic              tx_pin,
  input  logic              lpbk_en,
  input  logic              lpbk_src,
  input  logic              fmt9,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              idle_long,
  input  logic              wake_addr,
  input  logic              sleep_req,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              par_err,
  output logic              frm_err,
  output logic              idle_flag,
  output logic              asleep
);
  logic              line;
  logic              frm_done, frm_perr, frm_ferr, frm_addr, frm_busy;
  logic [CHAR_W-1:0] frm_data;
  logic              idle_pulse;
  logic              wake_ev, deliver;
  logic              asleep_q, asleep_d;
  logic              valid_q;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              perr_q, perr_d, ferr_q, ferr_d;

  sci_rx_src #(.STAGES(SYNCN)) u_src (
    .clk(clk), .rst_n(rst_n), .lpbk_en(lpbk_en), .lpbk_src(lpbk_src),
    .rx_pin(rx_pin), .tx_int(tx_int), .tx_pin(tx_pin), .line(line)
  );

  sci_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line), .fmt9(fmt9),
    .par_en(par_en), .par_odd(par_odd), .done(frm_done), .data(frm_data),
    .perr(frm_perr), .ferr(frm_ferr), .addr_mark(frm_addr), .busy(frm_busy)
  );

  sci_rx_idle #(.OVS(OVS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .line(line), .fmt9(fmt9),
    .long_mode(idle_long), .busy(frm_busy), .frame_done(frm_done),
    .idle_pulse(idle_pulse)
  );

  always_comb begin
    wake_ev  = asleep_q & (wake_addr ? (frm_done & frm_addr) : idle_pulse);
    deliver  = frm_done & (~asleep_q | (wake_addr & frm_addr));
    asleep_d = sleep_req ? 1'b1 : (wake_ev ? 1'b0 : asleep_q);
    data_d   = deliver ? frm_data : data_q;
    perr_d   = deliver ? frm_perr : perr_q;
    ferr_d   = deliver ? frm_ferr : ferr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      valid_q  <= 1'b0;
      data_q   <= '0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
    end else begin
      asleep_q <= asleep_d;
      valid_q  <= deliver;
      data_q   <= data_d;
      perr_q   <= perr_d;
      ferr_q   <= ferr_d;
    end
  end

  assign rx_data   = data_q;
  assign rx_valid  = valid_q;
  assign par_err   = perr_q;
  assign frm_err   = ferr_q;
  assign idle_flag = idle_pulse;
  assign asleep    = asleep_q;

  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && !wake_addr) |=> !rx_valid); // R9
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && !wake_addr && idle_pulse && !sleep_req) |=> !asleep_q); // R10
  AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && wake_addr && frm_done && frm_addr && !sleep_req) |=> (!asleep_q && rx_valid)); // R11
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R1
endmodule

// File: tb/sci_rx_wake_bench.sv
`timescale 1ns/1ps
module sci_rx_wake_bench;
  localparam int OVS = 16;
  localparam int NV  = 9;
  // {fmt9, par_en, par_odd, bits[8:0], stop, exp_data[8:0], exp_perr, exp_ferr}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 9'h0A5, 1'b1, 9'h0A5, 1'b0, 1'b0},  // R1
    {1'b0, 1'b0, 1'b0, 9'h03C, 1'b1, 9'h03C, 1'b0, 1'b0},  // R1
    {1'b1, 1'b0, 1'b0, 9'h1C3, 1'b1, 9'h1C3, 1'b0, 1'b0},  // R2
    {1'b1, 1'b0, 1'b0, 9'h055, 1'b1, 9'h055, 1'b0, 1'b0},  // R2
    {1'b0, 1'b1, 1'b0, 9'h081, 1'b1, 9'h081, 1'b0, 1'b0},  // R3 even ok
    {1'b0, 1'b1, 1'b0, 9'h083, 1'b1, 9'h083, 1'b1, 1'b0},  // R3 even bad
    {1'b0, 1'b1, 1'b1, 9'h083, 1'b1, 9'h083, 1'b0, 1'b0},  // R3 odd ok
    {1'b1, 1'b1, 1'b1, 9'h10F, 1'b1, 9'h10F, 1'b0, 1'b0},  // R3 odd ok 9-bit
    {1'b1, 1'b1, 1'b0, 9'h10F, 1'b1, 9'h10F, 1'b1, 1'b0}   // R3 even bad 9-bit
  };

  logic clk, rst_n;
  logic rx_pin, tx_int, tx_pin, lpbk_en, lpbk_src;
  logic fmt9, par_en, par_odd, idle_long, wake_addr, sleep_req;
  logic [8:0] rx_data;
  logic rx_valid, par_err, frm_err, idle_flag, asleep;

  int nchk, nerr, vcnt, icnt, route;
  bit finished;

  sci_rx_wake u_sci_rx_wake (
    .clk(clk), .rst_n(rst_n), .tick16(1'b1), .rx_pin(rx_pin), .tx_int(tx_int),
    .tx_pin(tx_pin), .lpbk_en(lpbk_en), .lpbk_src(lpbk_src), .fmt9(fmt9),
    .par_en(par_en), .par_odd(par_odd), .idle_long(idle_long),
    .wake_addr(wake_addr), .sleep_req(sleep_req), .rx_data(rx_data),
    .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err),
    .idle_flag(idle_flag), .asleep(asleep)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && rx_valid)  vcnt++;
    if (rst_n && idle_flag) icnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_line(input logic v);
    case (route)
      0: rx_pin = v;
      1: tx_int = v;
      default: tx_pin = v;
    endcase
  endtask

  task automatic send(input logic [8:0] bits, input int nb, input logic stopv);
    set_line(1'b0); cyc(OVS);
    for (int i = 0; i < nb; i++) begin
      set_line(bits[i]); cyc(OVS);
    end
    set_line(stopv); cyc(OVS);
    set_line(1'b1);
  endtask

  task automatic nap;
    sleep_req = 1'b1; cyc(1); sleep_req = 1'b0; cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int v0, i0;
    nchk = 0; nerr = 0; vcnt = 0; icnt = 0; route = 0; finished = 0;
    rst_n = 1'b0; rx_pin = 1'b1; tx_int = 1'b1; tx_pin = 1'b1;
    lpbk_en = 1'b0; lpbk_src = 1'b0; fmt9 = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    idle_long = 1'b0; wake_addr = 1'b0; sleep_req = 1'b0;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);
    // R13 reset state
    check("R13 rx_valid", rx_valid, 0);
    check("R13 rx_data", rx_data, 0);
    check("R13 par_err", par_err, 0);
    check("R13 frm_err", frm_err, 0);
    check("R13 asleep", asleep, 0);
    cyc(300);
    check("R8 no idle before first char", icnt, 0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      logic [23:0] e;
      e = VEC[k];
      fmt9 = e[23]; par_en = e[22]; par_odd = e[21];
      v0 = vcnt;
      send(e[20:12], e[23] ? 9 : 8, e[11]);
      cyc(4);
      check($sformatf("R1/R2/R3 vec%0d count", k), vcnt, v0 + 1);
      check($sformatf("R1/R2 vec%0d data", k), rx_data, e[10:2]);
      check($sformatf("R3 vec%0d par_err", k), par_err, e[1]);
      check($sformatf("R4 vec%0d frm_err", k), frm_err, e[0]);
      cyc(40);
    end
    fmt9 = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    cyc(300);

    // R6 short idle mode
    idle_long = 1'b0; i0 = icnt;
    send(9'h0FF, 8, 1'b1);
    cyc(40);
    check("R6 short idle early", icnt, i0 + 1);
    cyc(300);
    check("R8 single idle per period", icnt, i0 + 1);

    // R7 long idle mode
    idle_long = 1'b1; i0 = icnt;
    send(9'h0FF, 8, 1'b1);
    cyc(40);
    check("R7 long idle not yet", icnt, i0);
    cyc(250);
    check("R7 long idle later", icnt, i0 + 1);
    idle_long = 1'b0;
    cyc(50);

    // R9 / R10 idle wakeup
    wake_addr = 1'b0;
    nap();
    check("R9 asleep set", asleep, 1);
    v0 = vcnt;
    send(9'h05A, 8, 1'b1);
    cyc(4);
    check("R9 no char while asleep", vcnt, v0);
    cyc(300);
    check("R10 idle clears asleep", asleep, 0);
    v0 = vcnt;
    send(9'h033, 8, 1'b1);
    cyc(4);
    check("R10 delivered after wake", vcnt, v0 + 1);
    check("R10 data after wake", rx_data, 9'h033);
    cyc(300);

    // R11 address-mark wakeup, 8-bit
    wake_addr = 1'b1;
    nap();
    v0 = vcnt;
    send(9'h012, 8, 1'b1);
    cyc(300);
    check("R11 unmarked ignored", vcnt, v0);
    check("R11 idle does not wake", asleep, 1);
    send(9'h092, 8, 1'b1);
    cyc(4);
    check("R11 marked delivered", vcnt, v0 + 1);
    check("R11 marked data", rx_data, 9'h092);
    check("R11 asleep cleared", asleep, 0);
    cyc(50);
    // R11 address-mark wakeup, 9-bit
    fmt9 = 1'b1;
    nap();
    v0 = vcnt;
    send(9'h0FF, 9, 1'b1);
    cyc(4);
    check("R11 9-bit unmarked ignored", vcnt, v0);
    send(9'h101, 9, 1'b1);
    cyc(4);
    check("R11 9-bit marked delivered", vcnt, v0 + 1);
    check("R11 9-bit data", rx_data, 9'h101);
    check("R11 9-bit asleep cleared", asleep, 0);
    fmt9 = 1'b0; wake_addr = 1'b0;
    cyc(300);

    // R5 start glitch
    v0 = vcnt;
    rx_pin = 1'b0; cyc(4); rx_pin = 1'b1;
    cyc(400);
    check("R5 glitch rejected", vcnt, v0);

    // R4 framing error
    v0 = vcnt;
    send(9'h00F, 8, 1'b0);
    cyc(4);
    check("R4 framing count", vcnt, v0 + 1);
    check("R4 framing flag", frm_err, 1);
    check("R4 framing data", rx_data, 9'h00F);
    cyc(500);

    // R12 source selection
    lpbk_en = 1'b1; lpbk_src = 1'b0;
    v0 = vcnt; route = 0;
    send(9'h0A5, 8, 1'b1);
    cyc(40);
    check("R12 pin ignored in loopback", vcnt, v0);
    route = 1;
    send(9'h06E, 8, 1'b1);
    cyc(4);
    check("R12 internal source count", vcnt, v0 + 1);
    check("R12 internal source data", rx_data, 9'h06E);
    cyc(40);
    lpbk_src = 1'b1; v0 = vcnt;
    send(9'h0B1, 8, 1'b1);
    cyc(40);
    check("R12 internal ignored when pin src", vcnt, v0);
    route = 2;
    send(9'h0C4, 8, 1'b1);
    cyc(4);
    check("R12 tx pin source count", vcnt, v0 + 1);
    check("R12 tx pin source data", rx_data, 9'h0C4);
    cyc(20);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule